// File: doc/BRIEF.md
# Free Hole Allocation Selector

This block keeps a small table of free memory holes. Each slot holds a base address, a size and a valid flag. A client asks for a region by sending a size and a two-bit fit policy over a valid/ready handshake. One search engine walks the table and picks a hole under the chosen policy. It then returns the granted base address, or a fail flag when no hole is large enough. The chosen hole is shrunk from its low end.

Regions go back into the table through a separate free port, with no handshake. Each returned region becomes a new hole in the first empty slot. A next-fit pointer is kept between requests, so that repeated next-fit allocations rotate through the table instead of crowding its low slots.

Top module: `fit_hole_picker`

## Requirements
- R1: After reset every slot is empty, `req_ready` is 1, `rsp_valid` is 0, and a first allocation of any non-zero size fails.
- R2: Policy code 2'b00 (first fit) grants the lowest-indexed valid slot whose size is at least the requested size.
- R3: Policy code 2'b01 (next fit) searches from the slot after the one granted by the last successful next-fit request, wrapping from the last slot to slot 0. The pointer is slot 0 after reset. Grants under other policies, and failures, leave it unchanged.
- R4: Policy code 2'b10 (best fit) grants the smallest valid slot that is large enough. When sizes are equal, the lower index wins.
- R5: Policy code 2'b11 (worst fit) grants the largest valid slot if that slot is large enough. When sizes are equal, the lower index wins.
- R6: On a grant, `rsp_base` is the slot's old base. The slot's base then grows by the requested size and its size shrinks by the same amount. A slot whose size becomes zero turns invalid.
- R7: When no valid slot is large enough, the response carries `rsp_fail`=1 and the table is not changed.
- R8: A free with non-zero size stores its base and size in the lowest-indexed invalid slot, from the next cycle on. A free with size zero is ignored.
- R9: A free with non-zero size while every slot is valid raises `free_overflow` in the same cycle and leaves the table unchanged.
- R10: `rsp_valid` rises exactly DEPTH clock edges after the edge that accepts a request and stays high for one cycle. `req_ready` is 0 from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Engine idle, request accepted on this edge |
| req_size | input | SW | Requested size |
| req_policy | input | 2 | Fit policy code |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_fail | output | 1 | No hole large enough |
| rsp_base | output | AW | Granted base address |
| free_valid | input | 1 | Return a region |
| free_base | input | AW | Base of the returned region |
| free_size | input | SW | Size of the returned region |
| free_overflow | output | 1 | Returned region dropped, table full |

## Verification
The assertions assume that a free does not arrive while a search is running, because a slot written during the scan might be seen or missed depending on timing. The bench therefore issues every free while the engine is idle. The assertions also assume that request sizes are non-zero and that a base plus a size never wraps the address width, and all stimulus uses small non-zero sizes inside distinct address windows. Each scenario leaves the table in a known state, and the next scenario starts from that state. This lets the policy ties, the zero-size slot retirement and the pointer wrap be reached in sequence.

// File: rtl/fit_hole_picker.sv
module fit_hole_picker #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int SW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_size,
  input  logic [1:0]    req_policy,
  output logic          rsp_valid,
  output logic          rsp_fail,
  output logic [AW-1:0] rsp_base,
  input  logic          free_valid,
  input  logic [AW-1:0] free_base,
  input  logic [SW-1:0] free_size,
  output logic          free_overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [1:0] P_FIRST = 2'b00, P_NEXT = 2'b01, P_BEST = 2'b10, P_WORST = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} state_t;
  state_t st_q;

  logic [AW-1:0]    base_q [DEPTH];
  logic [SW-1:0]    size_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  logic [IW-1:0] cnt_q, start_q, nf_q, cand_q;
  logic [1:0]    pol_q;
  logic [SW-1:0] want_q, csz_q;
  logic          hit_q;

  logic [IW:0]   sum;
  logic [IW-1:0] idx, slot;
  logic          fits, better, full, do_free;

  assign sum  = {1'b0, start_q} + {1'b0, cnt_q};
  assign idx  = (sum >= (IW+1)'(DEPTH)) ? IW'(sum - (IW+1)'(DEPTH)) : sum[IW-1:0];
  assign fits = vld_q[idx] && (size_q[idx] >= want_q);

  always_comb begin
    case (pol_q)
      P_BEST:  better = !hit_q || (size_q[idx] < csz_q);
      P_WORST: better = !hit_q || (size_q[idx] > csz_q);
      default: better = !hit_q;
    endcase
  end

  always_comb begin
    slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) slot = IW'(i);
  end

  assign full          = &vld_q;
  assign do_free       = free_valid && (free_size != '0);
  assign free_overflow = do_free && full;

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_DONE);
  assign rsp_fail  = !hit_q;
  assign rsp_base  = hit_q ? base_q[cand_q] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      start_q <= '0;
      nf_q    <= '0;
      cand_q  <= '0;
      pol_q   <= P_FIRST;
      want_q  <= '0;
      csz_q   <= '0;
      hit_q   <= 1'b0;
      vld_q   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          st_q    <= S_SCAN;
          cnt_q   <= '0;
          pol_q   <= req_policy;
          want_q  <= req_size;
          start_q <= (req_policy == P_NEXT) ? nf_q : '0;
          hit_q   <= 1'b0;
        end
        S_SCAN: begin
          if (fits && better) begin
            hit_q  <= 1'b1;
            cand_q <= idx;
            csz_q  <= size_q[idx];
          end
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= S_DONE;
        end
        default: begin
          st_q <= S_IDLE;
          if (hit_q) begin
            base_q[cand_q] <= base_q[cand_q] + AW'(want_q);
            size_q[cand_q] <= size_q[cand_q] - want_q;
            if (size_q[cand_q] == want_q) vld_q[cand_q] <= 1'b0;
            if (pol_q == P_NEXT) nf_q <= (cand_q == LAST) ? '0 : cand_q + 1'b1;
          end
        end
      endcase
      if (do_free && !full) begin
        base_q[slot] <= free_base;
        size_q[slot] <= free_size;
        vld_q[slot]  <= 1'b1;
      end
    end
  end

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_grant_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fail) |-> (vld_q[cand_q] && size_q[cand_q] >= want_q));
  assert_fail_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail && !free_valid) |=> $stable(vld_q));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_overflow && !rsp_valid) |=> $stable(vld_q));
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid || rsp_fail || pol_q != P_NEXT) |=> $stable(nf_q));
endmodule

// File: tb/sim_fit_hole_picker.sv
module sim_fit_hole_picker;
  localparam int DEPTH = 4, AW = 16, SW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, free_valid = 1'b0;
  logic [SW-1:0] req_size = '0, free_size = '0;
  logic [1:0] req_policy = '0;
  logic [AW-1:0] free_base = '0;
  logic req_ready, rsp_valid, rsp_fail, free_overflow;
  logic [AW-1:0] rsp_base;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fit_hole_picker #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_policy(req_policy), .rsp_valid(rsp_valid),
    .rsp_fail(rsp_fail), .rsp_base(rsp_base), .free_valid(free_valid),
    .free_base(free_base), .free_size(free_size), .free_overflow(free_overflow));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_free(input int b, input int s, input bit exp_ovf, input string req);
    @(negedge clk);
    free_valid = 1'b1; free_base = AW'(b); free_size = SW'(s);
    #1 check(req, free_overflow, exp_ovf);
    @(posedge clk);
    @(negedge clk);
    free_valid = 1'b0;
  endtask

  task automatic alloc(input int s, input int pol, input bit exp_fail, input int exp_base,
                       input string req);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_size = SW'(s); req_policy = 2'(pol);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " ready low while busy (R10)"}, req_ready, 0);
    while (!rsp_valid && n < 50) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    check({req, " latency (R10)"}, n, DEPTH);
    check({req, " fail flag"}, rsp_fail, exp_fail);
    if (!exp_fail) check({req, " base"}, rsp_base, exp_base);
    @(posedge clk);
    @(negedge clk);
    check({req, " response one cycle (R10)"}, rsp_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 no response after reset", rsp_valid, 0);
    check("R1 no overflow after reset", free_overflow, 0);
    alloc(1, 0, 1, 0, "R1 empty table fails");
  endtask

  task automatic t_fill;
    do_free('h100, 16, 0, "R8 free slot0");
    do_free('h200, 64, 0, "R8 free slot1");
    do_free('h300, 32, 0, "R8 free slot2");
    do_free('h400, 48, 0, "R8 free slot3");
    do_free('h500, 8, 1, "R9 overflow when full");
  endtask

  task automatic t_policies;
    alloc(20, 0, 0, 'h200, "R2 first fit");
    alloc(30, 2, 0, 'h300, "R4 best fit");
    alloc(10, 3, 0, 'h400, "R5 worst fit");
  endtask

  task automatic t_next_fit;
    alloc(5, 1, 0, 'h100, "R3 next fit from slot0");
    alloc(5, 1, 0, 'h214, "R3 next fit advances, R6 shrink");
    alloc(12, 1, 0, 'h40A, "R3 next fit skips small");
    alloc(11, 1, 0, 'h105, "R3 next fit wraps, R6 exact");
  endtask

  task automatic t_fail_keeps;
    alloc(50, 0, 1, 0, "R7 no hole large enough");
    alloc(39, 3, 0, 'h219, "R7 table unchanged after fail");
  endtask

  task automatic t_refill_ties;
    do_free('h600, 0, 0, "R8 zero free ignored");
    do_free('h700, 26, 0, "R8 free to lowest invalid");
    do_free('h800, 25, 0, "R8 zero free took no slot");
    do_free('h900, 4, 1, "R9 overflow again");
    alloc(1, 3, 0, 'h700, "R5 worst fit tie lower index");
    alloc(20, 2, 0, 'h701, "R4 best fit tie lower index");
    alloc(2, 2, 0, 'h31E, "R4 best fit exact");
    alloc(3, 1, 0, 'h800, "R3 pointer held by other policies");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_policies();
    t_next_fit();
    t_fail_keeps();
    t_refill_ties();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule